// File: doc/BRIEF.md
# Cascadable Bidirectional Pixel Line Sampler

This block is the input stage of a display column driver. On every clock it can take one group of six 8-bit colour samples from a parallel bus and store them into a line buffer of 384 channels. A start token tells it when to begin. Once started, it writes consecutive six-channel groups on the clock edges that follow. After 64 writes the line is full. It then stops by itself and sends a one-clock carry pulse to the next device in the chain.

Each device has two cascade pins, A and B. The direction input decides which of them receives the start token and which one sends the carry. It also decides whether the line fills from the low channels upward or from the high channels downward. This allows a row of devices to be chained in either direction. The lower three bytes of the bus and the upper three bytes each have their own inversion control, which flips every bit of those bytes before they are stored.

The buffer is presented as a flat vector to the second-stage latch that follows this block. A buffer cell keeps its value until it is overwritten. After reset, no cell has a defined value until it is written.

Top module: `pix_line_sampler`

## Requirements
- R1: While `rst_n` is low and after it is released, `cas_a_o` and `cas_b_o` are 0 and no fill is running.
- R2: A fill starts on a rising edge of the start pin. The start pin is `cas_a_i` when `dir_i`=1 and `cas_b_i` when `dir_i`=0. The bus is not captured on the clock edge that sees the start. It is captured on each of the next CHANNELS/GROUP edges.
- R3: When the fill was started with `dir_i`=1, capture k (counting from 0) writes channels k*GROUP to k*GROUP+GROUP-1.
- R4: When the fill was started with `dir_i`=0, capture k writes group CHANNELS/GROUP-1-k. The first capture therefore goes to the highest six channels.
- R5: Bus byte j is `pix_i[8j+7:8j]`. It goes to channel (group base + j). Channel c appears at `line_o[8c+7:8c]`.
- R6: While `inv_lo_i`=1, bytes 0 to 2 are complemented before they are stored. While `inv_hi_i`=1, bytes 3 to 5 are complemented. Each control acts only on its own half of the bus. For example, 0x07 is stored as 0xF8 and 0x15 as 0xEA.
- R7: When no fill is running, bus data is ignored and `line_o` does not change.
- R8: In the cycle that follows the last capture, the carry goes high for exactly one clock. It appears on `cas_b_o` if `dir_i`=1 and on `cas_a_o` if `dir_i`=0. At all other times both pins are low.
- R9: If the start pin stays high for many cycles, it starts only one fill.
- R10: `cas_a_oe` is the inverse of `dir_i`, and `cas_b_oe` is equal to `dir_i`.
- R11: A new rising edge on the start pin during a fill restarts the fill from the first group. That edge writes nothing.
- R12: The fill order (R3 or R4) is decided by the value of `dir_i` at the start edge. It stays in force until the line is full, even if `dir_i` changes during the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dir_i | input | 1 | 1: start on A, fill upward, carry on B. 0: the reverse |
| cas_a_i | input | 1 | Cascade pin A, input side |
| cas_a_o | output | 1 | Cascade pin A, carry output |
| cas_a_oe | output | 1 | Cascade pin A output enable |
| cas_b_i | input | 1 | Cascade pin B, input side |
| cas_b_o | output | 1 | Cascade pin B, carry output |
| cas_b_oe | output | 1 | Cascade pin B output enable |
| inv_lo_i | input | 1 | Complement bytes 0 to 2 |
| inv_hi_i | input | 1 | Complement bytes 3 to 5 |
| pix_i | input | GROUP*BITS | Six samples, byte j at bits 8j+7:8j |
| line_o | output | CHANNELS*BITS | Line buffer, channel c at bits 8c+7:8c |

## Verification
The bench builds the block with CHANNELS=24, GROUP=6 and BITS=8, so a full line takes four captures. With a line this short, the following cases all fit into a few hundred cycles: completing a fill, the carry pulse, a start pin held high for longer than a whole fill, a restart near the last group, and a direction change in the middle of a fill. The group-order and byte-lane logic is the same as at the default size. Only the counter width and the number of groups differ.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;

  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;

  // Group written by a given capture step, for a fill order fixed at the start edge.
  function automatic int unsigned group_of(input int unsigned step,
                                           input int unsigned last,
                                           input fill_dir_e   d);
    return (d == FILL_UP) ? step : (last - step);
  endfunction

endpackage

// File: rtl/pls_token_ctrl.sv
`timescale 1ns/1ps
module pls_token_ctrl
  import pls_pkg::*;
#(
  parameter int STEPS = 64,
  localparam int GW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_i,
  input  logic          cas_a_i,
  input  logic          cas_b_i,
  output logic          busy_o,
  output logic          start_rise_o,
  output logic          wr_en_o,
  output logic [GW-1:0] wr_grp_o,
  output logic          carry_o
);

  localparam logic [GW-1:0] LAST_STEP = GW'(STEPS - 1);

  logic          prev_q, prev_d;
  logic          busy_q, busy_d;
  logic [GW-1:0] cnt_q, cnt_d;
  fill_dir_e     dir_q, dir_d;
  logic          carry_q, carry_d;

  logic          start_sel;
  logic          start_rise;
  logic          wr_en;
  logic          last_step;
  logic          run_en;

  // Start pin follows the live direction; a held level is seen only once.
  assign start_sel  = dir_i ? cas_a_i : cas_b_i;
  assign start_rise = start_sel & ~prev_q;
  assign wr_en      = busy_q & ~start_rise;
  assign last_step  = (cnt_q == LAST_STEP);
  assign run_en     = start_rise | wr_en;

  always_comb begin
    prev_d  = start_sel;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    carry_d = 1'b0;
    if (start_rise) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      dir_d  = dir_i ? FILL_UP : FILL_DOWN;
    end else if (wr_en) begin
      busy_d  = ~last_step;
      cnt_d   = last_step ? '0 : cnt_q + GW'(1);
      carry_d = last_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      carry_q <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= FILL_UP;
    end else if (run_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
    end
  end

  assign busy_o       = busy_q;
  assign start_rise_o = start_rise;
  assign wr_en_o      = wr_en;
  assign wr_grp_o     = GW'(group_of(32'(cnt_q), 32'(LAST_STEP), dir_q));
  assign carry_o      = carry_q;

endmodule

// File: rtl/pls_invert.sv
`timescale 1ns/1ps
module pls_invert #(
  parameter int GROUP = 6,
  parameter int BITS  = 8,
  localparam int HALF  = GROUP / 2,
  localparam int BUS_W = GROUP * BITS
) (
  input  logic [BUS_W-1:0] data_i,
  input  logic             inv_lo_i,
  input  logic             inv_hi_i,
  output logic [BUS_W-1:0] data_o
);

  for (genvar j = 0; j < GROUP; j++) begin : g_lane
    if (j < HALF) begin : g_lo
      assign data_o[j*BITS +: BITS] = data_i[j*BITS +: BITS] ^ {BITS{inv_lo_i}};
    end else begin : g_hi
      assign data_o[j*BITS +: BITS] = data_i[j*BITS +: BITS] ^ {BITS{inv_hi_i}};
    end
  end

endmodule

// File: rtl/pls_line_store.sv
`timescale 1ns/1ps
module pls_line_store #(
  parameter int GROUP = 6,
  parameter int BITS  = 8,
  parameter int STEPS = 64,
  localparam int GW     = $clog2(STEPS),
  localparam int BUS_W  = GROUP * BITS,
  localparam int LINE_W = STEPS * GROUP * BITS
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [GW-1:0]     wr_grp_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [LINE_W-1:0] line_o
);

  // Data cells carry no reset; their content is undefined until written.
  for (genvar g = 0; g < STEPS; g++) begin : g_grp
    logic grp_en;
    assign grp_en = wr_en_i & (wr_grp_i == GW'(g));
    for (genvar j = 0; j < GROUP; j++) begin : g_cell
      logic [BITS-1:0] cell_q;
      always_ff @(posedge clk) begin
        if (grp_en) begin
          cell_q <= wr_data_i[j*BITS +: BITS];
        end
      end
      assign line_o[(g*GROUP + j)*BITS +: BITS] = cell_q;
    end
  end

endmodule

// File: rtl/pix_line_sampler.sv
`timescale 1ns/1ps
module pix_line_sampler #(
  parameter int CHANNELS = 384,
  parameter int GROUP    = 6,
  parameter int BITS     = 8,
  localparam int STEPS  = CHANNELS / GROUP,
  localparam int GW     = $clog2(STEPS),
  localparam int BUS_W  = GROUP * BITS,
  localparam int LINE_W = CHANNELS * BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic              cas_a_i,
  output logic              cas_a_o,
  output logic              cas_a_oe,
  input  logic              cas_b_i,
  output logic              cas_b_o,
  output logic              cas_b_oe,
  input  logic              inv_lo_i,
  input  logic              inv_hi_i,
  input  logic [BUS_W-1:0]  pix_i,
  output logic [LINE_W-1:0] line_o
);

  logic          busy;
  logic          start_rise;
  logic          wr_en;
  logic [GW-1:0] wr_grp;
  logic          carry;
  logic [BUS_W-1:0] pix_fix;

  pls_token_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_i        (dir_i),
    .cas_a_i      (cas_a_i),
    .cas_b_i      (cas_b_i),
    .busy_o       (busy),
    .start_rise_o (start_rise),
    .wr_en_o      (wr_en),
    .wr_grp_o     (wr_grp),
    .carry_o      (carry)
  );

  pls_invert #(.GROUP(GROUP), .BITS(BITS)) u_inv (
    .data_i   (pix_i),
    .inv_lo_i (inv_lo_i),
    .inv_hi_i (inv_hi_i),
    .data_o   (pix_fix)
  );

  pls_line_store #(.GROUP(GROUP), .BITS(BITS), .STEPS(STEPS)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_grp_i  (wr_grp),
    .wr_data_i (pix_fix),
    .line_o    (line_o)
  );

  // Pin roles follow the live direction input.
  assign cas_a_oe = ~dir_i;
  assign cas_b_oe = dir_i;
  assign cas_a_o  = carry & ~dir_i;
  assign cas_b_o  = carry & dir_i;

endmodule

// File: rtl/pls_checker.sv
`timescale 1ns/1ps
module pls_checker #(
  parameter int STEPS  = 64,
  parameter int LINE_W = 3072,
  localparam int RW    = $clog2(STEPS + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_rise,
  input logic              cas_a_o,
  input logic              cas_b_o,
  input logic [LINE_W-1:0] line_o
);

  logic [RW-1:0] run_q;
  logic          carry_any;

  assign carry_any = cas_a_o | cas_b_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (start_rise) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + RW'(1);
    end else begin
      run_q <= '0;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(STEPS)); // R2

  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    carry_any |=> !carry_any); // R8

  AST_CARRY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> carry_any); // R8

  AST_CARRY_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    carry_any |-> $fell(busy)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(line_o)); // R7

  AST_PINS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cas_a_o && cas_b_o)); // R8

endmodule

bind pix_line_sampler pls_checker #(.STEPS(STEPS), .LINE_W(LINE_W)) u_pls_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .start_rise (start_rise),
  .cas_a_o    (cas_a_o),
  .cas_b_o    (cas_b_o),
  .line_o     (line_o)
);

// File: tb/pix_line_sampler_bench.sv
`timescale 1ns/1ps
module pix_line_sampler_bench;

  localparam int CH    = 24;
  localparam int GR    = 6;
  localparam int BI    = 8;
  localparam int STEPS = CH / GR;

  logic clk = 1'b0;
  logic rst_n;
  logic dir, a_in, b_in, inv_lo, inv_hi;
  logic [GR*BI-1:0] pix;
  logic a_out, a_oe, b_out, b_oe;
  logic [CH*BI-1:0] line;

  int nchk = 0;
  int nfail = 0;
  string cur = "R1";

  // reference model state
  int  ref_line [CH];
  bit  ref_known[CH];
  int  grp_q[$];
  bit  ref_carry;
  bit  ref_prev;

  always #2.5 clk = ~clk;

  pix_line_sampler #(.CHANNELS(CH), .GROUP(GR), .BITS(BI)) u_pix_line_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_i    (dir),
    .cas_a_i  (a_in),
    .cas_a_o  (a_out),
    .cas_a_oe (a_oe),
    .cas_b_i  (b_in),
    .cas_b_o  (b_out),
    .cas_b_oe (b_oe),
    .inv_lo_i (inv_lo),
    .inv_hi_i (inv_hi),
    .pix_i    (pix),
    .line_o   (line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit sel, rise;
    if (!rst_n) begin
      ref_prev  = 0;
      ref_carry = 0;
      grp_q.delete();
      return;
    end
    sel  = dir ? a_in : b_in;
    rise = sel && !ref_prev;
    ref_prev  = sel;
    ref_carry = 0;
    if (rise) begin
      grp_q.delete();
      for (int k = 0; k < STEPS; k++) grp_q.push_back(dir ? k : STEPS - 1 - k);
    end else if (grp_q.size() > 0) begin
      int g;
      g = grp_q.pop_front();
      for (int j = 0; j < GR; j++) begin
        int v;
        v = int'(pix[j*BI +: BI]);
        if ((j < GR/2 && inv_lo) || (j >= GR/2 && inv_hi)) v = v ^ 8'hFF;
        ref_line[g*GR + j]  = v;
        ref_known[g*GR + j] = 1;
      end
      if (grp_q.size() == 0) ref_carry = 1;
    end
  endtask

  task automatic compare();
    bit ok_line;
    int bad_c;
    int bad_a;
    // R10 enables
    chk((a_oe == !dir) && (b_oe == dir), "R10", "oe pair", {a_oe, b_oe}, {!dir, dir});
    // R8 carry pins (R1 during reset)
    chk((a_out == (ref_carry && !dir)) && (b_out == (ref_carry && dir)),
        rst_n ? "R8" : "R1", "carry pins", {a_out, b_out},
        {ref_carry && !dir, ref_carry && dir});
    ok_line = 1;
    bad_c = 0;
    bad_a = 0;
    for (int c = 0; c < CH; c++) begin
      if (ref_known[c] && ok_line && int'(line[c*BI +: BI]) != ref_line[c]) begin
        ok_line = 0;
        bad_c = c;
        bad_a = int'(line[c*BI +: BI]);
      end
    end
    chk(ok_line, cur, $sformatf("line channel %0d", bad_c), bad_a,
        ok_line ? 0 : ref_line[bad_c]);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic data_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      pix = {$urandom, $urandom};
      cycle();
    end
  endtask

  // one start pulse on the pin selected by d, then enough cycles to finish
  task automatic fill(input logic d);
    dir = d;
    if (d) a_in = 1'b1; else b_in = 1'b1;
    pix = {$urandom, $urandom};
    cycle();
    a_in = 1'b0;
    b_in = 1'b0;
    data_cycles(STEPS + 2);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < CH; c++) begin
      ref_known[c] = 0;
      ref_line[c]  = 0;
    end
    rst_n = 1'b0; dir = 1'b1; a_in = 1'b0; b_in = 1'b0;
    inv_lo = 1'b0; inv_hi = 1'b0; pix = '0;
    ref_prev = 0; ref_carry = 0;
    @(negedge clk);
    // R1: reset state
    cur = "R1";
    data_cycles(3);
    rst_n = 1'b1;
    data_cycles(3);            // R1 idle after release, data ignored

    cur = "R2 R3 R5";          // upward fill, start edge writes nothing
    fill(1'b1);
    cur = "R7";                // idle after full line
    data_cycles(5);

    cur = "R4 R5";             // downward fill, carry on pin A
    fill(1'b0);
    data_cycles(3);

    cur = "R6";                // per-half inversion
    inv_lo = 1'b1; inv_hi = 1'b0;
    fill(1'b1);
    inv_lo = 1'b0; inv_hi = 1'b1;
    fill(1'b0);
    inv_lo = 1'b1; inv_hi = 1'b1;
    dir = 1'b1; a_in = 1'b1; cycle(); a_in = 1'b0;
    for (int i = 0; i < STEPS + 1; i++) begin
      pix = {8'h15, 8'h07, 8'h15, 8'h07, 8'h15, 8'h07};
      inv_hi = i[0];
      cycle();
    end
    inv_lo = 1'b0; inv_hi = 1'b0;

    cur = "R9";                // start pin held longer than a fill
    dir = 1'b1; a_in = 1'b1;
    data_cycles(STEPS + 6);
    a_in = 1'b0;
    data_cycles(4);

    cur = "R11";               // restart in the middle of a fill
    dir = 1'b0; b_in = 1'b1; cycle(); b_in = 1'b0;
    data_cycles(STEPS - 2);
    b_in = 1'b1; pix = {$urandom, $urandom}; cycle(); b_in = 1'b0;
    data_cycles(STEPS + 2);

    cur = "R11";               // restart coinciding with the last capture
    dir = 1'b1; a_in = 1'b1; cycle(); a_in = 1'b0;
    data_cycles(STEPS - 1);
    a_in = 1'b1; pix = {$urandom, $urandom}; cycle(); a_in = 1'b0;
    data_cycles(STEPS + 2);

    cur = "R12";               // direction changes during a fill
    dir = 1'b1; a_in = 1'b1; cycle(); a_in = 1'b0;
    data_cycles(1);
    dir = 1'b0;
    data_cycles(STEPS + 2);
    dir = 1'b0; b_in = 1'b1; cycle(); b_in = 1'b0;
    data_cycles(2);
    dir = 1'b1;
    data_cycles(STEPS + 2);

    cur = "R7";
    data_cycles(6);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule